// File: doc/BRIEF.md
# Testable controlled-swap storage cell

This block stores one bit per lane using only 3-in/3-out controlled-swap primitives, and it can check itself for stuck-at faults. Each lane has two primitives. The first is a hold multiplexer steered by the enable. The second steers the stored bit onto a true/complement output pair. The output pair is selected by two control pins, `c1_i` and `c2_i`. A system-clocked flop captures the hold multiplexer on every rising edge. The multiplexer feeds the stored bit back when the enable is low, so the flop takes `d_i` only when `en_i` is high.

The two control pins choose one of four modes:
- Direct mode (c1=0, c2=1): the cell acts as an ordinary enable-gated store.
- Swapped mode (c1=1, c2=0): the output pair is exchanged.
- Zero test mode (c1=c2=0) and one test mode (c1=c2=1): both outputs are pinned to the test level.

When the whole input vector is uniform (`c1_i`, `c2_i`, `en_i` and every `d_i` bit all at the level of `c1_i`), all six primitive lines of every lane must carry that level. A combinational flag reports any line that does not. This lets a tester find stuck-at-1 faults with the all-zero vector and stuck-at-0 faults with the all-one vector.

Top module: `cswap_store_cell`

## Requirements
- R1: The primitive maps (ctl, x, y) to outputs ctl_o=ctl, x_o=(~ctl&x)|(ctl&y) and y_o=(ctl&x)|(~ctl&y), for all eight input vectors.
- R2: For every input vector, the primitive has as many 1s at its outputs as at its inputs.
- R3: A rising edge with `rst_i`=1 clears the stored bit to 0, whatever `en_i` and `d_i` are. In direct mode this reads afterwards as q_o=0 and qx_o=1.
- R4: A rising edge with `en_i`=1 and `rst_i`=0 loads `d_i` into the stored bit, in any mode.
- R5: A rising edge with `en_i`=0 leaves the stored bit unchanged, and `d_i` has no effect on it.
- R6: In direct mode (c1_i=0, c2_i=1), q_o equals the stored bit and qx_o equals its complement.
- R7: In swapped mode (c1_i=1, c2_i=0), q_o equals the complement of the stored bit and qx_o equals the stored bit.
- R8: In zero test mode (c1_i=c2_i=0), q_o and qx_o are 0. With en_i=0, d_i=0 and the stored bit 0, test_fail_o is 0.
- R9: In one test mode (c1_i=c2_i=1), q_o and qx_o are 1. With en_i=1 and d_i all 1, test_fail_o is 0 from the first edge after the vector is applied.
- R10: test_fail_o is 1 whenever the input vector is uniform and any of the six primitive lines of any lane differs from that level. Examples: the stored bit is 1 under the zero vector; the stored bit is still 0 under the one vector before its edge; a stuck control line in the output primitive.
- R11: test_fail_o is 0 whenever c1_i differs from c2_i, or en_i or any bit of d_i differs from c1_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset of the stored bits |
| d_i | input | WIDTH | Data to store, one bit per lane |
| en_i | input | 1 | Load enable shared by all lanes |
| c1_i | input | 1 | First mode control line |
| c2_i | input | 1 | Second mode control line |
| q_o | output | WIDTH | True output (forced to the test level in test modes) |
| qx_o | output | WIDTH | Complement output (forced to the test level in test modes) |
| test_fail_o | output | 1 | High when a uniform test vector meets a line at the wrong level |

## Verification
Loading through the enable and judging the fault flag can happen in the same cycle. The one test vector is itself a write of all ones, so the flag depends on state that the same edge is about to change. The bench applies the one vector while the stored bit is 0, then reads the flag before the edge (expected high) and after it (expected low). It does the same for the zero vector over a stored 1, where no edge can clear the bit because the enable is low. Stuck-at faults are imitated by forcing one control line of the output primitive, and the flag must rise only under the uniform vector of the matching polarity.

// File: rtl/cswap_pkg.sv
package cswap_pkg;

  // Mode code is {c1, c2}.
  typedef enum logic [1:0] {
    MODE_ZERO_TEST = 2'b00,
    MODE_DIRECT    = 2'b01,
    MODE_SWAPPED   = 2'b10,
    MODE_ONE_TEST  = 2'b11
  } cell_mode_e;

  typedef struct packed {
    logic ctl;
    logic x;
    logic y;
  } trio_t;

  localparam int unsigned LINES_PER_GATE = 3;
  localparam int unsigned GATES_PER_LANE = 2;
  localparam int unsigned LINES_PER_LANE = LINES_PER_GATE * GATES_PER_LANE;

  // Controlled swap: ctl passes through, x/y exchange when ctl is high.
  function automatic trio_t cswap_map(input trio_t in);
    trio_t res;
    res.ctl = in.ctl;
    res.x   = in.ctl ? in.y : in.x;
    res.y   = in.ctl ? in.x : in.y;
    return res;
  endfunction

  function automatic logic [1:0] trio_ones(input trio_t t);
    return {1'b0, t.ctl} + {1'b0, t.x} + {1'b0, t.y};
  endfunction

  function automatic cell_mode_e decode_mode(input logic c1, input logic c2);
    return cell_mode_e'({c1, c2});
  endfunction

endpackage

// File: rtl/cswap_gate.sv
module cswap_gate
  import cswap_pkg::*;
(
  input  logic ctl_i,
  input  logic x_i,
  input  logic y_i,
  output logic ctl_o,
  output logic x_o,
  output logic y_o
);

  trio_t in_w;
  trio_t out_w;

  assign in_w  = '{ctl: ctl_i, x: x_i, y: y_i};
  assign out_w = cswap_map(in_w);

  assign ctl_o = out_w.ctl;
  assign x_o   = out_w.x;
  assign y_o   = out_w.y;

  always_comb begin
    if (!$isunknown({ctl_i, x_i, y_i, ctl_o, x_o, y_o})) begin
      AST_ONES_KEPT: assert (trio_ones('{ctl: ctl_i, x: x_i, y: y_i}) ==
                             trio_ones('{ctl: ctl_o, x: x_o, y: y_o})); // R2
    end
  end

endmodule

// File: rtl/cswap_state_reg.sv
module cswap_state_reg #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) q_o <= '0;
    else       q_o <= nxt_i;
  end

endmodule

// File: rtl/cswap_test_mon.sv
module cswap_test_mon
  import cswap_pkg::*;
#(
  parameter int unsigned WIDTH = 1
) (
  input  logic                             c1_i,
  input  logic                             c2_i,
  input  logic                             en_i,
  input  logic [WIDTH-1:0]                 d_i,
  input  logic [WIDTH*LINES_PER_LANE-1:0]  lines_i,
  output logic                             vec_uniform_o,
  output logic                             line_mismatch_o,
  output logic                             fail_o
);

  localparam int unsigned NLINES = WIDTH * LINES_PER_LANE;

  logic level_w;

  assign level_w         = c1_i;
  assign vec_uniform_o   = (c2_i == level_w) && (en_i == level_w) &&
                           (d_i == {WIDTH{level_w}});
  assign line_mismatch_o = |(lines_i ^ {NLINES{level_w}});
  assign fail_o          = vec_uniform_o && line_mismatch_o;

endmodule

// File: rtl/cswap_store_cell.sv
module cswap_store_cell
  import cswap_pkg::*;
#(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             en_i,
  input  logic             c1_i,
  input  logic             c2_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] qx_o,
  output logic             test_fail_o
);

  localparam int unsigned NLINES = WIDTH * LINES_PER_LANE;

  // Control lines into the output primitives, named so they can be observed.
  logic sel_lo_w;
  logic sel_hi_w;
  assign sel_lo_w = c1_i;
  assign sel_hi_w = c2_i;

  logic [WIDTH-1:0]  stored_w;
  logic [WIDTH-1:0]  next_w;
  logic [NLINES-1:0] lines_w;
  logic              vec_uniform_w;
  logic              line_mismatch_w;
  cell_mode_e        mode_w;

  assign mode_w = decode_mode(sel_lo_w, sel_hi_w);

  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    logic hold_ctl;
    logic hold_alt;
    logic pass_q;

    // Hold multiplexer: en low keeps the stored bit, en high takes d.
    cswap_gate u_hold (
      .ctl_i (en_i),
      .x_i   (stored_w[b]),
      .y_i   (d_i[b]),
      .ctl_o (hold_ctl),
      .x_o   (next_w[b]),
      .y_o   (hold_alt)
    );

    // Output steering: the stored bit selects between the two control lines.
    cswap_gate u_out (
      .ctl_i (stored_w[b]),
      .x_i   (sel_lo_w),
      .y_i   (sel_hi_w),
      .ctl_o (pass_q),
      .x_o   (q_o[b]),
      .y_o   (qx_o[b])
    );

    assign lines_w[b*LINES_PER_LANE +: LINES_PER_LANE] =
      {hold_ctl, next_w[b], hold_alt, pass_q, q_o[b], qx_o[b]};
  end

  cswap_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .nxt_i (next_w),
    .q_o   (stored_w)
  );

  cswap_test_mon #(.WIDTH(WIDTH)) u_mon (
    .c1_i            (c1_i),
    .c2_i            (c2_i),
    .en_i            (en_i),
    .d_i             (d_i),
    .lines_i         (lines_w),
    .vec_uniform_o   (vec_uniform_w),
    .line_mismatch_o (line_mismatch_w),
    .fail_o          (test_fail_o)
  );

  AST_LOAD_WHEN_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |=> (stored_w == $past(d_i))); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (stored_w == $past(stored_w))); // R5

  AST_DIRECT_OUTS: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_w == MODE_DIRECT) |-> (q_o == stored_w && qx_o == ~stored_w)); // R6

  AST_SWAPPED_OUTS: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_w == MODE_SWAPPED) |-> (q_o == ~stored_w && qx_o == stored_w)); // R7

  AST_TEST_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    (sel_lo_w == sel_hi_w) |-> (q_o == {WIDTH{sel_lo_w}} && qx_o == {WIDTH{sel_lo_w}})); // R8

  AST_FLAG_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (!vec_uniform_w || !line_mismatch_w) |-> !test_fail_o); // R11

endmodule

// File: tb/tb_cswap_store_cell.sv
`timescale 1ns/1ps
module tb_cswap_store_cell;

  localparam int unsigned WIDTH = 1;

  logic             clk = 1'b0;
  logic             rst;
  logic [WIDTH-1:0] d;
  logic             en, c1, c2;
  logic [WIDTH-1:0] q, qx;
  logic             tfail;

  logic pa, pb, pc, pp, pq, pr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cswap_store_cell #(.WIDTH(WIDTH)) dut (
    .clk_i(clk), .rst_i(rst), .d_i(d), .en_i(en), .c1_i(c1), .c2_i(c2),
    .q_o(q), .qx_o(qx), .test_fail_o(tfail)
  );

  cswap_gate prim (
    .ctl_i(pa), .x_i(pb), .y_i(pc), .ctl_o(pp), .x_o(pq), .y_o(pr)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic dv, input logic ev, input logic c1v, input logic c2v);
    @(negedge clk);
    d = {WIDTH{dv}}; en = ev; c1 = c1v; c2 = c2v;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic v);
    drive(v, 1'b1, 1'b0, 1'b1);
    tick();
    drive(~v, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_primitive();
    for (int v = 0; v < 8; v++) begin
      logic a, b, c, eq, er;
      {a, b, c} = v[2:0];
      pa = a; pb = b; pc = c;
      #1;
      eq = (~a & b) | (a & c);
      er = (a & b) | (~a & c);
      chk($sformatf("R1 prim vec %0d", v), {5'd0, pp, pq, pr}, {5'd0, a, eq, er});
      chk($sformatf("R2 prim ones vec %0d", v),
          8'(int'(pp) + int'(pq) + int'(pr)), 8'(int'(a) + int'(b) + int'(c)));
    end
  endtask

  task automatic t_reset();
    put_bit(1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R3 reset q", {7'd0, q}, 8'h00);
    chk("R3 reset qx", {7'd0, qx}, 8'h01);
  endtask

  task automatic t_write();
    put_bit(1'b1);
    chk("R4 load 1", {7'd0, q}, 8'h01);
    put_bit(1'b0);
    chk("R4 load 0", {7'd0, q}, 8'h00);
  endtask

  task automatic t_hold();
    put_bit(1'b1);
    for (int i = 0; i < 3; i++) begin
      drive(i[0], 1'b0, 1'b0, 1'b1);
      tick();
      chk("R5 hold with d toggling", {7'd0, q}, 8'h01);
    end
  endtask

  task automatic t_modes();
    put_bit(1'b1);
    chk("R6 direct q stored1", {6'd0, q, qx}, 8'h02);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 swapped stored1", {6'd0, q, qx}, 8'h01);
    chk("R11 flag low swapped", {7'd0, tfail}, 8'h00);
    put_bit(1'b0);
    chk("R6 direct q stored0", {6'd0, q, qx}, 8'h01);
    chk("R11 flag low direct", {7'd0, tfail}, 8'h00);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 swapped stored0", {6'd0, q, qx}, 8'h02);
  endtask

  task automatic t_zero_test();
    put_bit(1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 zero mode outs", {6'd0, q, qx}, 8'h00);
    chk("R8 zero mode flag clean", {7'd0, tfail}, 8'h00);
    put_bit(1'b1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 zero mode outs stored1", {6'd0, q, qx}, 8'h00);
    chk("R10 zero vector over stored 1", {7'd0, tfail}, 8'h01);
    tick();
    chk("R10 zero vector keeps flag", {7'd0, tfail}, 8'h01);
  endtask

  task automatic t_one_test();
    put_bit(1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R9 one mode outs before edge", {6'd0, q, qx}, 8'h03);
    chk("R10 one vector before load", {7'd0, tfail}, 8'h01);
    tick();
    chk("R9 one vector after load", {7'd0, tfail}, 8'h00);
    chk("R9 one mode outs after edge", {6'd0, q, qx}, 8'h03);
    drive(1'b0, 1'b1, 1'b1, 1'b1);
    chk("R11 non-uniform d flag low", {7'd0, tfail}, 8'h00);
    chk("R9 one mode outs with d=0", {6'd0, q, qx}, 8'h03);
    tick();
    drive(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R4 load in test mode", {7'd0, q}, 8'h00);
  endtask

  task automatic t_faults();
    put_bit(1'b0);
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R9 clean before stuck-at-0", {7'd0, tfail}, 8'h00);
    force dut.sel_hi_w = 1'b0;
    #1;
    chk("R10 stuck-at-0 seen in one mode", {7'd0, tfail}, 8'h01);
    drive(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R11 stuck-at-0 hidden in direct", {7'd0, tfail}, 8'h00);
    release dut.sel_hi_w;
    put_bit(1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 clean before stuck-at-1", {7'd0, tfail}, 8'h00);
    force dut.sel_lo_w = 1'b1;
    #1;
    chk("R10 stuck-at-1 seen in zero mode", {7'd0, tfail}, 8'h01);
    release dut.sel_lo_w;
    #1;
    chk("R10 flag clears after release", {7'd0, tfail}, 8'h00);
  endtask

  initial begin
    rst = 1'b1; d = '0; en = 1'b0; c1 = 1'b0; c2 = 1'b1;
    pa = 1'b0; pb = 1'b0; pc = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset state q", {7'd0, q}, 8'h00);
    rst = 1'b0;
    t_primitive();
    t_reset();
    t_write();
    t_hold();
    t_modes();
    t_zero_test();
    t_one_test();
    t_faults();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule